// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a 64-bit effective address into a real address by walking an in-memory radix tree. A request carries the address, the access kind (read, write or fetch) and the current machine mode. When translation is off for that access side in hypervisor state, the address passes straight through. Otherwise the two top address bits pick a partition id and a process id, the process id indexes a process table, and the tree is walked one 64-bit entry per memory read. The fan-out of every level is taken from the parent entry.

At a leaf, the walker forms the real address and the page size. It then marks the entry as referenced, and as changed when the access is a write, and stores the entry back only when one of those bits was actually new. Every walk ends with a one-cycle completion pulse. That pulse carries either a fault class or the translation: real address, log2 page size, read/write/execute permission and the address of the leaf entry. Access-rights checking and translation-cache filling sit outside this block.

Top module: `radix_walker`

## Requirements
- R1: When `hv`=1 and translation is off for the access side (`ir`=0 for a fetch, `acc`=2; `dr`=0 otherwise), `done` rises one cycle after `start` with `fault`=0, `raddr` equal to `ea` with bits 63:60 cleared, `perm`=3'b111, `psize`=12, and no memory request is made. With `hv`=0 the translation-off bits have no such effect.
- R2: In hypervisor state the quadrant `ea[63:62]` selects (partition, process) = (0, `pidr`) for 0, (`lpidr`, `pidr`) for 1, (`lpidr`, 0) for 2, (0, 0) for 3. The selection appears on `sel_lpid`/`sel_pid`. In guest state, quadrant 0 gives (`lpidr`, `pidr`) and quadrant 3 gives (`lpidr`, 0).
- R3: In guest state quadrants 1 and 2 end the walk with the segment fault (`fcause` bit 0) and no memory request.
- R4: The process-table entry is read at (`prtb_base` with bits 11:0 cleared) + process id × 16. If process id × 16 ≥ 2^(`prts`+12), the walk ends with the no-entry fault (`fcause` bit 1) and no memory request.
- R5: The process-table entry holds the initial remaining size in bits 61:56, the root directory base in bits 55:8 (the base is bits 55:8 shifted left by 8), and the root fan-out log2 in bits 4:0.
- R6: Before each directory read, a fan-out log2 below 5 or above the remaining size ends the walk with the bad-configuration fault (`fcause` bit 2).
- R7: The entry read at each level is at base + 8 × ((ea with bits 63:62 cleared) >> (remaining − fan-out) masked to fan-out bits).
- R8: A directory entry with bit 63 (valid) clear ends the walk with the no-entry fault. Otherwise the remaining size drops by the fan-out. If bit 62 (leaf) is clear, the entry's bits 55:8 and 4:0 give the next base and fan-out, laid out as in R5.
- R9: At a leaf, `raddr` takes bits 55:12 of the entry above the remaining size and the address bits below it. `psize` is the remaining size and `pte_addr` is the leaf's address.
- R10: After a leaf, bit 8 (referenced) is set, and bit 7 (changed) is set on writes. The entry is written back to `pte_addr` only if it differs. `perm` is 3'b101 ({exec, write, read}) on reads and fetches and 3'b111 on writes.
- R11: At most 5 directory levels are read. A walk that needs a sixth ends with the bad-configuration fault.
- R12: `mem_req` stays high with `mem_addr` and `mem_we` stable until `mem_ack`. Only one request is outstanding, and every address is 8-byte aligned.
- R13: `done` is a single-cycle pulse. When `fault`=1, exactly one `fcause` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| ea | input | 64 | Effective address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| hv | input | 1 | Hypervisor state |
| ir | input | 1 | Fetch-side translation enable |
| dr | input | 1 | Data-side translation enable |
| lpidr | input | 32 | Current partition id |
| pidr | input | 32 | Current process id |
| prtb_base | input | 64 | Process table base address |
| prts | input | 5 | Process table size: 2^(prts+12) bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Store data |
| mem_ack | input | 1 | Request accepted / data valid |
| mem_rdata | input | 64 | Load data |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk failed |
| fcause | output | 3 | Bit 0 segment, bit 1 no entry, bit 2 bad configuration |
| raddr | output | 64 | Real address |
| psize | output | 6 | log2 page size |
| perm | output | 3 | {exec, write, read} permission |
| pte_addr | output | 64 | Address of the leaf entry |
| sel_lpid | output | 32 | Selected partition id |
| sel_pid | output | 32 | Selected process id |

## Verification
The embedded properties watch the memory handshake on every cycle: requests holding steady until accepted, aligned addresses, and write-backs always carrying the referenced bit and, on writes, the changed bit. They also watch the completion pulse, the one-hot fault class and the level-count bound. What only directed scenarios can show is the arithmetic of the walk. That covers quadrant selection, process-table overflow at the exact size boundary, index extraction per level, large-page address merging, the exact five-level limit, and whether a write-back is skipped when the referenced and changed bits were already present.

// File: rtl/rw_pkg.sv
package rw_pkg;

    localparam int XLEN     = 64;
    localparam int V_BIT    = 63;
    localparam int LEAF_BIT = 62;
    localparam int REF_BIT  = 8;
    localparam int CHG_BIT  = 7;
    localparam int NLS_W    = 5;
    localparam int SZ_W     = 6;
    localparam int MIN_NLS  = 5;

    localparam int FC_SEG    = 0;
    localparam int FC_NOPTE  = 1;
    localparam int FC_BADCFG = 2;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2
    } acc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRT,
        S_CALC,
        S_DIR,
        S_RCW
    } st_t;

    typedef struct packed {
        logic [XLEN-1:0] raddr;
        logic [SZ_W-1:0] psize;
        logic [2:0]      perm;
    } xlat_t;

    function automatic logic [XLEN-1:0] dir_base(input logic [XLEN-1:0] e);
        return {8'b0, e[55:8], 8'b0};
    endfunction

    function automatic logic [XLEN-1:0] leaf_rpn(input logic [XLEN-1:0] e);
        return {8'b0, e[55:12], 12'b0};
    endfunction

endpackage

// File: rtl/rw_qualify.sv
module rw_qualify #(
    parameter int LPID_W = 32,
    parameter int PID_W  = 32
) (
    input  logic              hv,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpidr,
    input  logic [PID_W-1:0]  pidr,
    output logic [LPID_W-1:0] q_lpid,
    output logic [PID_W-1:0]  q_pid,
    output logic              seg
);
    always_comb begin
        q_lpid = '0;
        q_pid  = '0;
        seg    = 1'b0;
        if (hv) begin
            unique case (quad)
                2'd0: q_pid = pidr;
                2'd1: begin q_lpid = lpidr; q_pid = pidr; end
                2'd2: q_lpid = lpidr;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin q_lpid = lpidr; q_pid = pidr; end
                2'd3: q_lpid = lpidr;
                default: seg = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rw_index.sv
module rw_index
    import rw_pkg::*;
(
    input  logic [XLEN-1:0]  eam,
    input  logic [XLEN-1:0]  base,
    input  logic [NLS_W-1:0] nls,
    input  logic [SZ_W-1:0]  rem,
    output logic [XLEN-1:0]  ent_addr,
    output logic             bad
);
    logic [SZ_W-1:0] shamt;
    logic [XLEN-1:0] idx;

    always_comb begin
        bad      = (nls < NLS_W'(MIN_NLS)) || ({1'b0, nls} > rem);
        shamt    = rem - {1'b0, nls};
        idx      = (eam >> shamt) & ((64'd1 << nls) - 64'd1);
        ent_addr = base + (idx << 3);
    end
endmodule

// File: rtl/rw_leaf.sv
module rw_leaf
    import rw_pkg::*;
(
    input  logic [XLEN-1:0] entry,
    input  logic [XLEN-1:0] eam,
    input  logic [SZ_W-1:0] rem_after,
    input  logic            is_wr,
    output logic [XLEN-1:0] leaf_ra,
    output logic [XLEN-1:0] upd_entry,
    output logic            changed
);
    logic [XLEN-1:0] low_mask;

    always_comb begin
        low_mask  = (64'd1 << rem_after) - 64'd1;
        leaf_ra   = (leaf_rpn(entry) & ~low_mask) | (eam & low_mask);
        upd_entry = entry | (64'd1 << REF_BIT);
        if (is_wr) upd_entry = upd_entry | (64'd1 << CHG_BIT);
        changed   = (upd_entry != entry);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import rw_pkg::*;
#(
    parameter int MAX_LVL   = 5,
    parameter int LPID_W    = 32,
    parameter int PID_W     = 32,
    parameter int PAGE_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       ea,
    input  logic [1:0]        acc,
    input  logic              hv,
    input  logic              ir,
    input  logic              dr,
    input  logic [LPID_W-1:0] lpidr,
    input  logic [PID_W-1:0]  pidr,
    input  logic [63:0]       prtb_base,
    input  logic [4:0]        prts,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fcause,
    output logic [63:0]       raddr,
    output logic [5:0]        psize,
    output logic [2:0]        perm,
    output logic [63:0]       pte_addr,
    output logic [LPID_W-1:0] sel_lpid,
    output logic [PID_W-1:0]  sel_pid
);
    localparam int LVL_W = $clog2(MAX_LVL + 1);
    localparam logic [63:0] RM_MASK = 64'h0FFF_FFFF_FFFF_FFFF;

    st_t              st;
    logic [XLEN-1:0]  eam_q, base_q;
    logic [NLS_W-1:0] nls_q;
    logic [SZ_W-1:0]  rem_q, rem_after;
    logic [LVL_W-1:0] lvl_q;
    logic             wr_q;

    logic [LPID_W-1:0] q_lpid;
    logic [PID_W-1:0]  q_pid;
    logic              seg, bypass, ovf;
    logic [XLEN-1:0]   pid64, prt_addr, ent_addr, leaf_ra, upd_entry;
    logic              bad, changed;
    xlat_t             xl;

    rw_qualify #(.LPID_W(LPID_W), .PID_W(PID_W)) u_qual (
        .hv(hv), .quad(ea[63:62]), .lpidr(lpidr), .pidr(pidr),
        .q_lpid(q_lpid), .q_pid(q_pid), .seg(seg)
    );

    rw_index u_idx (
        .eam(eam_q), .base(base_q), .nls(nls_q), .rem(rem_q),
        .ent_addr(ent_addr), .bad(bad)
    );

    rw_leaf u_leaf (
        .entry(mem_rdata), .eam(eam_q), .rem_after(rem_after), .is_wr(wr_q),
        .leaf_ra(leaf_ra), .upd_entry(upd_entry), .changed(changed)
    );

    always_comb begin
        bypass    = hv && ((acc_t'(acc) == ACC_EX) ? !ir : !dr);
        pid64     = 64'(q_pid);
        ovf       = (pid64 >> ({1'b0, prts} + 6'd8)) != 64'd0;
        prt_addr  = (prtb_base & ~64'hFFF) + (pid64 << 4);
        rem_after = rem_q - {1'b0, nls_q};
        xl.raddr  = leaf_ra;
        xl.psize  = rem_after;
        xl.perm   = {1'b1, wr_q, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            eam_q     <= '0;
            base_q    <= '0;
            nls_q     <= '0;
            rem_q     <= '0;
            lvl_q     <= '0;
            wr_q      <= 1'b0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            fault     <= 1'b0;
            fcause    <= '0;
            raddr     <= '0;
            psize     <= '0;
            perm      <= '0;
            pte_addr  <= '0;
            sel_lpid  <= '0;
            sel_pid   <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    eam_q  <= {2'b00, ea[61:0]};
                    wr_q   <= (acc_t'(acc) == ACC_WR);
                    lvl_q  <= '0;
                    fault  <= 1'b0;
                    fcause <= '0;
                    raddr  <= '0;
                    psize  <= '0;
                    perm   <= '0;
                    if (bypass) begin
                        done     <= 1'b1;
                        raddr    <= ea & RM_MASK;
                        psize    <= SZ_W'(PAGE_LOG2);
                        perm     <= 3'b111;
                        pte_addr <= '0;
                        sel_lpid <= '0;
                        sel_pid  <= '0;
                    end else if (seg) begin
                        done     <= 1'b1;
                        fault    <= 1'b1;
                        fcause   <= 3'(1 << FC_SEG);
                        sel_lpid <= '0;
                        sel_pid  <= '0;
                    end else begin
                        sel_lpid <= q_lpid;
                        sel_pid  <= q_pid;
                        if (ovf) begin
                            done   <= 1'b1;
                            fault  <= 1'b1;
                            fcause <= 3'(1 << FC_NOPTE);
                        end else begin
                            mem_req  <= 1'b1;
                            mem_we   <= 1'b0;
                            mem_addr <= prt_addr;
                            st       <= S_PRT;
                        end
                    end
                end
                S_PRT: if (mem_ack) begin
                    mem_req <= 1'b0;
                    base_q  <= dir_base(mem_rdata);
                    nls_q   <= mem_rdata[NLS_W-1:0];
                    rem_q   <= mem_rdata[61:56];
                    st      <= S_CALC;
                end
                S_CALC: begin
                    if (bad || lvl_q == LVL_W'(MAX_LVL)) begin
                        done   <= 1'b1;
                        fault  <= 1'b1;
                        fcause <= 3'(1 << FC_BADCFG);
                        st     <= S_IDLE;
                    end else begin
                        mem_req  <= 1'b1;
                        mem_we   <= 1'b0;
                        mem_addr <= ent_addr;
                        lvl_q    <= lvl_q + 1'b1;
                        st       <= S_DIR;
                    end
                end
                S_DIR: if (mem_ack) begin
                    mem_req <= 1'b0;
                    if (!mem_rdata[V_BIT]) begin
                        done   <= 1'b1;
                        fault  <= 1'b1;
                        fcause <= 3'(1 << FC_NOPTE);
                        st     <= S_IDLE;
                    end else if (mem_rdata[LEAF_BIT]) begin
                        raddr    <= xl.raddr;
                        psize    <= xl.psize;
                        perm     <= xl.perm;
                        pte_addr <= mem_addr;
                        if (changed) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_wdata <= upd_entry;
                            st        <= S_RCW;
                        end else begin
                            done <= 1'b1;
                            st   <= S_IDLE;
                        end
                    end else begin
                        base_q <= dir_base(mem_rdata);
                        nls_q  <= mem_rdata[NLS_W-1:0];
                        rem_q  <= rem_after;
                        st     <= S_CALC;
                    end
                end
                S_RCW: if (mem_ack) begin
                    mem_req <= 1'b0;
                    mem_we  <= 1'b0;
                    done    <= 1'b1;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R12: request held steady until accepted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R12: entries are 8-byte aligned
    a_r12_addr_align: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[2:0] == 3'b000);

    // R13: completion is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13: exactly one fault class on a failed walk
    a_r13_cause_onehot: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> $countones(fcause) == 1);

    // R10: every write-back marks the entry referenced
    a_r10_wb_ref: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[REF_BIT]);

    // R10: write accesses also mark it changed
    a_r10_wb_chg: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && wr_q |-> mem_wdata[CHG_BIT]);

    // R11: level counter bounded by the limit
    a_r11_lvl_bound: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_W'(MAX_LVL));

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        st == S_IDLE |-> !mem_req);

endmodule

// File: tb/radix_walker_tb.sv
module radix_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] ea = '0;
    logic [1:0]  acc = '0;
    logic        hv = 1'b1, ir = 1'b1, dr = 1'b1;
    logic [31:0] lpidr = 32'd7, pidr = 32'd5;
    logic [63:0] prtb_base = 64'h10000;
    logic [4:0]  prts = 5'd0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        done, fault;
    logic [2:0]  fcause, perm;
    logic [63:0] raddr, pte_addr;
    logic [5:0]  psize;
    logic [31:0] sel_lpid, sel_pid;

    int nvec = 0, nerr = 0, cyc = 0, nrd = 0, nwr = 0;
    logic [63:0] mem [logic [63:0]];

    radix_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .ea(ea), .acc(acc),
        .hv(hv), .ir(ir), .dr(dr), .lpidr(lpidr), .pidr(pidr),
        .prtb_base(prtb_base), .prts(prts),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fcause(fcause), .raddr(raddr),
        .psize(psize), .perm(perm), .pte_addr(pte_addr),
        .sel_lpid(sel_lpid), .sel_pid(sel_pid)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                nwr++;
            end else begin
                mem_rdata <= rd_mem(mem_addr);
                nrd++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nvec++; nerr++;
            $display("FAIL R13 watchdog: got no done, expected done");
            summary();
        end
    end

    function automatic logic [63:0] mk_pt(input logic [5:0] rts, input logic [63:0] b, input logic [4:0] n);
        return {2'b00, rts, b[55:8], 3'b000, n};
    endfunction
    function automatic logic [63:0] mk_dir(input logic [63:0] b, input logic [4:0] n);
        return {1'b1, 1'b0, 6'b0, b[55:8], 3'b000, n};
    endfunction
    function automatic logic [63:0] mk_leaf(input logic [63:0] rpn, input logic r, input logic c);
        return {1'b1, 1'b1, 6'b0, rpn[55:12], 3'b000, r, c, 7'b0};
    endfunction
    function automatic logic [63:0] idx_of(input logic [63:0] a, input int rem, input int n);
        return ({2'b00, a[61:0]} >> (rem - n)) & ((64'd1 << n) - 64'd1);
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] a, input logic [1:0] k);
        @(negedge clk);
        nrd = 0; nwr = 0;
        ea = a; acc = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    localparam logic [63:0] EA_A = 64'h0000_0000_0123_4567;
    localparam logic [63:0] EA_B = 64'h0000_0000_0A00_1234;
    localparam logic [63:0] EA_C = 64'h0000_0000_1FE0_0000;
    localparam logic [63:0] EA_D = 64'h0000_00AB_CDEF_1234;
    logic [63:0] l2a;

    task automatic build();
        mem[64'h10000 + 5 * 16] = mk_pt(6'd30, 64'h20000, 5'd9);
        mem[64'h20000 + idx_of(EA_A, 30, 9) * 8] = mk_dir(64'h30000, 5'd9);
        l2a = 64'h30000 + idx_of(EA_A, 21, 9) * 8;
        mem[l2a] = mk_leaf(64'hABCDE000, 1'b0, 1'b0);
        mem[64'h20000 + idx_of(EA_B, 30, 9) * 8] = mk_leaf(64'h4000_0000, 1'b1, 1'b1);
        mem[64'h10000 + 6 * 16] = mk_pt(6'd40, 64'h40000, 5'd5);
        for (int k = 0; k < 5; k++)
            mem[64'h40000 + k * 64'h1000 + idx_of(EA_D, 40 - 5 * k, 5) * 8] =
                mk_dir(64'h40000 + (k + 1) * 64'h1000, 5'd5);
        mem[64'h10000 + 7 * 16] = mk_pt(6'd37, 64'h60000, 5'd5);
        for (int k = 0; k < 5; k++)
            mem[64'h60000 + k * 64'h1000 + idx_of(EA_D, 37 - 5 * k, 5) * 8] =
                (k == 4) ? mk_leaf(64'h7777_7000, 1'b1, 1'b0)
                         : mk_dir(64'h60000 + (k + 1) * 64'h1000, 5'd5);
    endtask

    task automatic t_reset();
        chk("R13 reset done", 64'(done), 0);
        chk("R12 reset req", 64'(mem_req), 0);
    endtask

    task automatic t_bypass();
        hv = 1; dr = 0; ir = 1;
        walk(64'hF123_4567_89AB_CDEF, 2'd0);
        chk("R1 bypass raddr", raddr, 64'h0123_4567_89AB_CDEF);
        chk("R1 bypass perm", 64'(perm), 7);
        chk("R1 bypass psize", 64'(psize), 12);
        chk("R1 bypass fault", 64'(fault), 0);
        chk("R1 bypass no mem", 64'(nrd + nwr), 0);
        dr = 1; ir = 0;
        walk(64'hA000_0000_0000_1000, 2'd2);
        chk("R1 fetch bypass raddr", raddr, 64'h0000_0000_0000_1000);
        ir = 1;
    endtask

    task automatic t_read_walk();
        walk(EA_A, 2'd0);
        chk("R9 raddr", raddr, 64'hABCDE567);
        chk("R9 psize", 64'(psize), 12);
        chk("R9 pte_addr", pte_addr, l2a);
        chk("R7 read count", 64'(nrd), 3);
        chk("R10 read perm", 64'(perm), 5);
        chk("R10 ref written once", 64'(nwr), 1);
        chk("R10 ref set only", rd_mem(l2a), mk_leaf(64'hABCDE000, 1'b1, 1'b0));
        chk("R2 q0 lpid", 64'(sel_lpid), 0);
        chk("R2 q0 pid", 64'(sel_pid), 5);
        walk(EA_A, 2'd0);
        chk("R10 no rewrite on read", 64'(nwr), 0);
        walk(EA_A, 2'd1);
        chk("R10 write perm", 64'(perm), 7);
        chk("R10 chg written", 64'(nwr), 1);
        chk("R10 chg set", rd_mem(l2a), mk_leaf(64'hABCDE000, 1'b1, 1'b1));
        walk(EA_A, 2'd1);
        chk("R10 no rewrite on write", 64'(nwr), 0);
    endtask

    task automatic t_large_invalid();
        walk(EA_B, 2'd0);
        chk("R9 large raddr", raddr, 64'h4000_1234);
        chk("R9 large psize", 64'(psize), 21);
        chk("R10 large no write", 64'(nwr), 0);
        walk(EA_C, 2'd0);
        chk("R8 invalid fault", 64'(fcause), 2);
        chk("R8 invalid reads", 64'(nrd), 2);
    endtask

    task automatic t_quadrants();
        walk({2'b01, EA_A[61:0]}, 2'd0);
        chk("R2 hv q1 lpid", 64'(sel_lpid), 7);
        chk("R2 hv q1 pid", 64'(sel_pid), 5);
        chk("R2 hv q1 raddr", raddr, 64'hABCDE567);
        walk({2'b10, EA_A[61:0]}, 2'd0);
        chk("R2 hv q2 lpid", 64'(sel_lpid), 7);
        chk("R2 hv q2 pid", 64'(sel_pid), 0);
        chk("R6 root nls 0 badcfg", 64'(fcause), 4);
        walk({2'b11, EA_A[61:0]}, 2'd0);
        chk("R2 hv q3 ids", {sel_lpid, sel_pid}, 0);
        hv = 0; dr = 0;
        walk(EA_A, 2'd0);
        chk("R2 guest q0 lpid", 64'(sel_lpid), 7);
        chk("R1 guest no bypass raddr", raddr, 64'hABCDE567);
        walk({2'b11, EA_A[61:0]}, 2'd0);
        chk("R2 guest q3 ids", {sel_lpid, sel_pid}, {32'd7, 32'd0});
        walk({2'b01, EA_A[61:0]}, 2'd0);
        chk("R3 guest q1 seg", 64'(fcause), 1);
        chk("R3 guest q1 no mem", 64'(nrd), 0);
        walk({2'b10, EA_A[61:0]}, 2'd1);
        chk("R3 guest q2 seg", {63'd0, fault}, 1);
        hv = 1; dr = 1;
    endtask

    task automatic t_overflow();
        pidr = 32'd256;
        walk(EA_A, 2'd0);
        chk("R4 overflow nopte", 64'(fcause), 2);
        chk("R4 overflow no mem", 64'(nrd), 0);
        prts = 5'd1;
        walk(EA_A, 2'd0);
        chk("R4 fits badcfg", 64'(fcause), 4);
        chk("R4 fits one read", 64'(nrd), 1);
        prts = 5'd0; pidr = 32'd5;
    endtask

    task automatic t_levels();
        pidr = 32'd6;
        walk(EA_D, 2'd0);
        chk("R11 sixth level badcfg", 64'(fcause), 4);
        chk("R11 five dir reads", 64'(nrd), 6);
        pidr = 32'd7;
        walk(EA_D, 2'd0);
        chk("R11 five levels ok", 64'(fault), 0);
        chk("R5 deep raddr", raddr, 64'h7777_7234);
        chk("R5 deep psize", 64'(psize), 12);
        pidr = 32'd5;
    endtask

    initial begin
        build();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_read_walk();
        t_large_invalid();
        t_quadrants();
        t_overflow();
        t_levels();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule